// File: doc/BRIEF.md
# SPI serial memory command controller

This block is the slave-side command front end of a 512-byte serial EEPROM. The serial clock, chip select and data-in pins are sampled in a faster system clock domain through two-flop synchronizers. Bus edges are found on the synchronized serial clock. The controller shifts in a one-byte instruction, then an address byte and data bytes, most significant bit first. It decodes six instructions. Read data or the status byte is streamed back on the serial output. SPI modes 0 and 3 both work, because input is taken only on rising edges and output only moves on falling edges.

Array reads go to an external byte-array memory through a read strobe and a nine-bit address, with combinational read data. Array writes collect in a 16-byte page buffer. When chip select rises, the buffer is written out through a write strobe, one byte per system clock. Write-enable set and clear events, and status writes, go to a separate status block. That block returns the live status byte: bit 1 is the write-enable flag, bits 3:2 are the protection bits, and bit 0 is the busy flag.

The state machine has nine states: IDLE (deselected), OPCODE, ADDR, RDATA, WDATA, SRREAD, SRWRITE, WAIT (ignore the bus until deselect) and COMMIT (page write-out).

Its transitions are:
- IDLE to OPCODE on a chip-select fall.
- OPCODE to WAIT after a write-enable set, a write-enable clear or an unknown opcode.
- OPCODE to SRREAD after a status read, to SRWRITE after a status write, and to ADDR after an array read or write.
- ADDR to RDATA or to WDATA once the address byte is in.
- SRWRITE to WAIT once its data byte is in.
- WDATA to COMMIT on a chip-select rise when the write was enabled and at least one byte is buffered.
- COMMIT to IDLE after the last page slot.
- Every other state to IDLE on a chip-select rise.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: Input bits are taken on rising edges of the serial clock, and the serial output changes only after falling edges, in both SPI mode 0 (clock idles low) and mode 3 (clock idles high).
- R2: Every byte is shifted MSB first. Opcodes have upper nibble 0000 and a low three-bit code: 110 write-enable set, 100 write-enable clear, 101 status read, 001 status write, 011 array read, 010 array write.
- R3: An array read uses a nine-bit address whose bit 8 is opcode bit 3 and whose low byte is the address byte. Bytes stream from consecutive addresses, wrapping from 0x1FF to 0x000.
- R4: An array write buffers data bytes in a 16-byte page. Address bits 3:0 wrap inside the page, and each slot keeps its last byte. After chip select rises, the buffered slots are written to memory only if status bit 1 was set when the opcode arrived, followed by a write-enable clear pulse. Otherwise memory is untouched.
- R5: Write-enable set (0000_0110) and clear (0000_0100) each produce one pulse. All further clocks are then ignored until deselect.
- R6: A status read returns the status byte MSB first and starts over with its bit 7 every eight clocks.
- R7: A status write forwards its data byte with a status-write pulse only when status bit 1 is set. Otherwise it has no effect.
- R8: An opcode outside the set produces no strobe and leaves the output disabled until chip select rises.
- R9: Whenever chip select is high, the output enable is low. After reset, no command is taken until chip select has fallen.
- R10: Opcode bit 3 is ignored for the four non-array instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso (low means high impedance) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 9 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, combinational from mem_addr |
| wel_set | output | 1 | Write-enable set pulse |
| wel_clr | output | 1 | Write-enable clear pulse |
| sr_wr | output | 1 | Status write pulse |
| sr_wdata | output | 8 | Status write data |
| sr_rdata | input | 8 | Live status byte (bit 1 write enable, bits 3:2 protection) |

## Verification
Array reads are run from random addresses with random lengths in both clock modes. Matching data in both modes separates correct edge use from a controller that samples or drives on the wrong edge. A read from 0x1F0 across the top of memory, and reads at the same low byte with opcode bit 3 set and clear, separate true nine-bit addressing and wrapping from a truncated address. Writes of more than 16 bytes starting mid-page, random writes, and writes without write enable separate page wrapping, last-byte-wins slots and enable gating from plain sequential stores. Status reads longer than one byte, commands followed by extra bytes, opcodes with bit 3 set, unknown opcodes and a select held low through reset each isolate one decode or ignore rule.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    localparam int ADDR_W = 9;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_SRREAD,
        ST_SRWRITE,
        ST_WAIT,
        ST_COMMIT
    } ctl_state_e;

    typedef enum logic [2:0] {
        K_WEN_SET,
        K_WEN_CLR,
        K_STAT_RD,
        K_STAT_WR,
        K_ARR_RD,
        K_ARR_WR,
        K_BAD
    } op_kind_e;

    // Bit 3 is not examined: it is address bit 8 for array commands
    // and a don't-care for the rest.
    function automatic op_kind_e op_classify(input logic [BYTE_W-1:0] op);
        op_kind_e k;
        if (op[7:4] != 4'h0) begin
            k = K_BAD;
        end else begin
            case (op[2:0])
                3'b110:  k = K_WEN_SET;
                3'b100:  k = K_WEN_CLR;
                3'b101:  k = K_STAT_RD;
                3'b001:  k = K_STAT_WR;
                3'b011:  k = K_ARR_RD;
                3'b010:  k = K_ARR_WR;
                default: k = K_BAD;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/spi_eeprom_sync.sv
module spi_eeprom_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[b]}};
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[b]};
                end
            end
            assign sync_out[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_eeprom_pagebuf.sv
module spi_eeprom_pagebuf #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);

    localparam int DEPTH = 1 << PAGE_W;

    logic [DATA_W-1:0] slots [DEPTH];
    logic [DEPTH-1:0]  filled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filled <= '0;
        end else if (clr) begin
            filled <= '0;
        end else if (wr_en) begin
            filled[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    assign rd_data   = slots[rd_idx];
    assign rd_valid  = filled[rd_idx];
    assign any_valid = |filled;

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
    import spi_eeprom_pkg::*;
#(
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              wel_set,
    output logic              wel_clr,
    output logic              sr_wr,
    output logic [BYTE_W-1:0] sr_wdata,
    input  logic [BYTE_W-1:0] sr_rdata
);

    localparam logic [PAGE_W-1:0] IDX_ONE  = {{(PAGE_W-1){1'b0}}, 1'b1};
    localparam logic [PAGE_W-1:0] IDX_LAST = '1;
    localparam int WEL_BIT = 1;

    // ---- synchronizers and edge detection -------------------------------
    // Chip select resets to "low" so that a select already held low at reset
    // produces no falling edge.
    logic [2:0] sync_q;
    logic       sck_s, cs_s, mosi_s;
    logic       sck_d, cs_d;
    logic       sck_rise, sck_fall, cs_fall, cs_rise;

    spi_eeprom_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b000)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({spi_mosi, spi_cs_n, spi_sck}),
        .sync_out(sync_q)
    );

    assign sck_s  = sync_q[0];
    assign cs_s   = sync_q[1];
    assign mosi_s = sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b0;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign cs_fall  = ~cs_s & cs_d;
    assign cs_rise  = cs_s & ~cs_d;

    // ---- state and datapath registers -----------------------------------
    ctl_state_e        state_q, state_d;
    logic [6:0]        sh_q;
    logic [2:0]        bcnt_q;
    logic [2:0]        oidx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              a8_q, wen_q, rd_q, ld_pend_q, dout_q;
    logic [BYTE_W-1:0] obyte_q;
    logic [PAGE_W-1:0] cidx_q;

    logic              receiving, rx_shift, byte_done;
    logic [BYTE_W-1:0] rx_byte;
    op_kind_e          op_kind;

    assign receiving = (state_q == ST_OPCODE) || (state_q == ST_ADDR) ||
                       (state_q == ST_WDATA)  || (state_q == ST_SRWRITE);
    assign rx_shift  = receiving && sck_rise;
    assign byte_done = rx_shift && (bcnt_q == 3'd7);
    assign rx_byte   = {sh_q, mosi_s};
    assign op_kind   = op_classify(rx_byte);

    // ---- page buffer ----------------------------------------------------
    logic              pb_clr, pb_wr, pb_valid, pb_any;
    logic [BYTE_W-1:0] pb_data;

    assign pb_wr  = (state_q == ST_WDATA) && byte_done && wen_q;
    assign pb_clr = ((state_q == ST_OPCODE) && byte_done && (op_kind == K_ARR_WR)) ||
                    ((state_q == ST_COMMIT) && (cidx_q == IDX_LAST));

    spi_eeprom_pagebuf #(
        .PAGE_W(PAGE_W),
        .DATA_W(BYTE_W)
    ) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pb_clr),
        .wr_en    (pb_wr),
        .wr_idx   (addr_q[PAGE_W-1:0]),
        .wr_data  (rx_byte),
        .rd_idx   (cidx_q),
        .rd_data  (pb_data),
        .rd_valid (pb_valid),
        .any_valid(pb_any)
    );

    // ---- next-state logic -----------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) state_d = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (cs_rise) begin
                    state_d = ST_IDLE;
                end else if (byte_done) begin
                    case (op_kind)
                        K_STAT_RD: state_d = ST_SRREAD;
                        K_STAT_WR: state_d = ST_SRWRITE;
                        K_ARR_RD:  state_d = ST_ADDR;
                        K_ARR_WR:  state_d = ST_ADDR;
                        default:   state_d = ST_WAIT;
                    endcase
                end
            end
            ST_ADDR: begin
                if (cs_rise)        state_d = ST_IDLE;
                else if (byte_done) state_d = rd_q ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA: begin
                if (cs_rise) state_d = (wen_q && pb_any) ? ST_COMMIT : ST_IDLE;
            end
            ST_SRWRITE: begin
                if (cs_rise)        state_d = ST_IDLE;
                else if (byte_done) state_d = ST_WAIT;
            end
            ST_RDATA, ST_SRREAD, ST_WAIT: begin
                if (cs_rise) state_d = ST_IDLE;
            end
            ST_COMMIT: begin
                if (cidx_q == IDX_LAST) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---- outputs and datapath -------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            bcnt_q    <= '0;
            oidx_q    <= '0;
            addr_q    <= '0;
            a8_q      <= 1'b0;
            wen_q     <= 1'b0;
            rd_q      <= 1'b0;
            ld_pend_q <= 1'b0;
            dout_q    <= 1'b0;
            obyte_q   <= '0;
            cidx_q    <= '0;
            mem_rd    <= 1'b0;
            mem_wr    <= 1'b0;
            mem_wdata <= '0;
            wel_set   <= 1'b0;
            wel_clr   <= 1'b0;
            sr_wr     <= 1'b0;
            sr_wdata  <= '0;
        end else begin
            mem_rd  <= 1'b0;
            mem_wr  <= 1'b0;
            wel_set <= 1'b0;
            wel_clr <= 1'b0;
            sr_wr   <= 1'b0;

            if (ld_pend_q) begin
                obyte_q   <= mem_rdata;
                ld_pend_q <= 1'b0;
            end

            if (rx_shift) begin
                sh_q   <= rx_byte[6:0];
                bcnt_q <= bcnt_q + 3'd1;
            end

            if ((state_q == ST_IDLE) && cs_fall) begin
                bcnt_q <= '0;
                oidx_q <= '0;
            end

            case (state_q)
                ST_OPCODE: begin
                    if (byte_done) begin
                        a8_q    <= rx_byte[3];
                        wen_q   <= sr_rdata[WEL_BIT];
                        rd_q    <= (op_kind == K_ARR_RD);
                        cidx_q  <= '0;
                        wel_set <= (op_kind == K_WEN_SET);
                        wel_clr <= (op_kind == K_WEN_CLR);
                    end
                end
                ST_ADDR: begin
                    if (byte_done) begin
                        addr_q <= {a8_q, rx_byte};
                        if (rd_q) begin
                            mem_rd    <= 1'b1;
                            ld_pend_q <= 1'b1;
                        end
                    end
                end
                ST_RDATA: begin
                    if (sck_fall) begin
                        dout_q <= obyte_q[~oidx_q];
                        oidx_q <= oidx_q + 3'd1;
                        if (oidx_q == 3'd7) begin
                            addr_q    <= addr_q + 9'd1;
                            mem_rd    <= 1'b1;
                            ld_pend_q <= 1'b1;
                        end
                    end
                end
                ST_SRREAD: begin
                    if (sck_fall) begin
                        if (oidx_q == 3'd0) begin
                            dout_q  <= sr_rdata[7];
                            obyte_q <= sr_rdata;
                        end else begin
                            dout_q <= obyte_q[~oidx_q];
                        end
                        oidx_q <= oidx_q + 3'd1;
                    end
                end
                ST_SRWRITE: begin
                    if (byte_done && sr_rdata[WEL_BIT]) begin
                        sr_wr    <= 1'b1;
                        sr_wdata <= rx_byte;
                    end
                end
                ST_WDATA: begin
                    if (pb_wr) begin
                        addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + IDX_ONE;
                    end
                end
                ST_COMMIT: begin
                    if (pb_valid) begin
                        mem_wr    <= 1'b1;
                        addr_q    <= {addr_q[ADDR_W-1:PAGE_W], cidx_q};
                        mem_wdata <= pb_data;
                    end
                    cidx_q <= cidx_q + IDX_ONE;
                    if (cidx_q == IDX_LAST) wel_clr <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign mem_addr    = addr_q;
    assign spi_miso    = dout_q;
    assign spi_miso_oe = (state_q == ST_RDATA) || (state_q == ST_SRREAD);

endmodule

// File: rtl/spi_eeprom_ctrl_chk.sv
module spi_eeprom_ctrl_chk #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic              spi_miso_oe,
    input logic              sck_fall,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              sr_wr,
    input logic              wel_set,
    input logic              wel_now
);

    // R1: while driving, the output moves only one cycle after a clock fall
    p_miso_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && $past(spi_miso_oe) && (spi_miso != $past(spi_miso)))
            |-> $past(sck_fall));

    // R9: a select held high for several cycles forces the output off
    p_hiz_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) &&
         $past(spi_cs_n, 3) && $past(spi_cs_n, 4)) |-> !spi_miso_oe);

    // R4: back-to-back commit writes stay in one page and climb
    p_page_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |->
            ((mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])) &&
             (mem_addr[PAGE_W-1:0] > $past(mem_addr[PAGE_W-1:0]))));

    // R5: at most one request strobe per cycle
    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, sr_wr, wel_set}));

    // R7: a status write is only issued while write enable was set
    p_srwr_needs_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr |-> $past(wel_now));

    // R8: no memory request while the output is off and select is high
    p_no_read_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) &&
         $past(spi_cs_n, 4)) |-> 1'b0);

endmodule

bind spi_eeprom_ctrl spi_eeprom_ctrl_chk #(
    .ADDR_W(spi_eeprom_pkg::ADDR_W),
    .PAGE_W(PAGE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_miso   (spi_miso),
    .spi_miso_oe(spi_miso_oe),
    .sck_fall   (sck_fall),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .sr_wr      (sr_wr),
    .wel_set    (wel_set),
    .wel_now    (sr_rdata[1])
);

// File: tb/sim_spi_eeprom_ctrl.sv
`timescale 1ns/1ps
module sim_spi_eeprom_ctrl;

    localparam int HALF = 160;     // serial half period, 8 system clocks
    localparam int SETTLE = 1000;  // wait after deselect, covers page commit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b0;
    logic spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic mem_rd, mem_wr, wel_set, wel_clr, sr_wr;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata, sr_wdata, sr_rdata;

    always #10 clk = ~clk;   // 50 MHz

    spi_eeprom_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .wel_set(wel_set), .wel_clr(wel_clr), .sr_wr(sr_wr),
        .sr_wdata(sr_wdata), .sr_rdata(sr_rdata)
    );

    function automatic logic [7:0] init_byte(input int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    // ---- behavioural memory and status block ----
    logic [7:0] mem [512];
    logic [7:0] exp_mem [512];
    logic       st_wel;
    logic [1:0] st_bp;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= init_byte(i);
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_wel <= 1'b0;
            st_bp  <= 2'b00;
        end else begin
            if (wel_set) st_wel <= 1'b1;
            if (wel_clr || sr_wr) st_wel <= 1'b0;
            if (sr_wr) st_bp <= sr_wdata[3:2];
        end
    end
    assign sr_rdata = {4'hF, st_bp, st_wel, 1'b0};

    // ---- monitors ----
    int n_wr = 0, n_rd = 0, n_strobe = 0, n_oe = 0, n_hiz_bad = 0, cs_hi_run = 0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_wr) n_wr++;
            if (mem_rd) n_rd++;
            if (mem_rd || mem_wr || sr_wr || wel_set || wel_clr) n_strobe++;
            if (spi_miso_oe) n_oe++;
            if (spi_cs_n) cs_hi_run++; else cs_hi_run = 0;
            if (cs_hi_run > 5 && spi_miso_oe) n_hiz_bad++;
        end
    end

    // ---- checking ----
    int n_chk = 0, n_fail = 0;
    logic exp_wel = 1'b0;
    logic [1:0] exp_bp = 2'b00;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {4'hF, exp_bp, exp_wel, 1'b0};
    endfunction

    // ---- serial host ----
    task automatic sel(input bit m3);
        spi_sck = m3;
        #(HALF);
        spi_cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic desel();
        #(HALF);
        spi_cs_n = 1'b1;
        #(SETTLE);
    endtask

    task automatic xfer(input bit m3, input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            if (m3) spi_sck = 1'b0;
            spi_mosi = tx[i];
            #(HALF);
            spi_sck = 1'b1;
            rx[i] = spi_miso;
            #(HALF);
            if (!m3) spi_sck = 1'b0;
        end
    endtask

    task automatic cmd1(input bit m3, input logic [7:0] op);
        logic [7:0] rx;
        sel(m3);
        xfer(m3, op, rx);
        desel();
    endtask

    task automatic read_status(input bit m3, input int nbytes, input string req);
        logic [7:0] rx;
        sel(m3);
        xfer(m3, 8'h05, rx);
        for (int k = 0; k < nbytes; k++) begin
            xfer(m3, 8'h00, rx);
            check(rx == exp_status(), req, rx, exp_status());
        end
        desel();
    endtask

    task automatic do_read(input bit m3, input logic [8:0] a, input int n, input bit a8_in_op);
        logic [7:0] rx;
        logic [8:0] p;
        sel(m3);
        xfer(m3, {4'h0, a8_in_op ? a[8] : 1'b0, 3'b011}, rx);
        xfer(m3, a[7:0], rx);
        for (int k = 0; k < n; k++) begin
            xfer(m3, 8'h00, rx);
            p = a + 9'(k);
            check(rx == exp_mem[p], m3 ? "R1 R2 R3 mode3 read" : "R1 R2 R3 mode0 read",
                  rx, exp_mem[p]);
        end
        desel();
    endtask

    task automatic do_write(input bit m3, input logic [8:0] a, input int n, input bit enabled);
        logic [7:0] rx, d;
        logic [8:0] p;
        sel(m3);
        xfer(m3, {4'h0, a[8], 3'b010}, rx);
        xfer(m3, a[7:0], rx);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            xfer(m3, d, rx);
            p = {a[8:4], 4'(a[3:0] + 4'(k))};
            if (enabled) exp_mem[p] = d;
        end
        desel();
        if (enabled) exp_wel = 1'b0;
    endtask

    // ---- watchdog ----
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // ---- main sequence ----
    initial begin
        logic [7:0] rx;
        int w0, s0, o0;
        void'($urandom(32'h5eed));
        for (int i = 0; i < 512; i++) exp_mem[i] = init_byte(i);

        // select held low through reset
        #200;
        rst_n = 1'b1;
        #100;
        check(spi_miso_oe == 1'b0, "R9 reset oe", spi_miso_oe, 0);
        check(n_strobe == 0, "R9 reset strobes", n_strobe, 0);
        xfer(1'b0, 8'h06, rx);      // no falling select: must be ignored
        desel();
        check(n_strobe == 0, "R9 no command without select fall", n_strobe, 0);
        read_status(1'b0, 1, "R9 R2 status after ignored enable");

        // status read wraps every eight clocks
        read_status(1'b1, 3, "R6 status repeat");

        // enable set, then extra bytes ignored
        s0 = n_strobe;
        sel(1'b0);
        xfer(1'b0, 8'h06, rx);
        xfer(1'b0, 8'h01, rx);
        xfer(1'b0, 8'h0C, rx);
        desel();
        exp_wel = 1'b1;
        check(n_strobe - s0 == 1, "R5 single pulse", n_strobe - s0, 1);
        read_status(1'b0, 1, "R5 enable set, trailing bytes ignored");

        // bit 3 ignored on non-array ops
        cmd1(1'b1, 8'h0C); exp_wel = 1'b0;
        read_status(1'b0, 1, "R10 clear with bit3");
        cmd1(1'b0, 8'h0E); exp_wel = 1'b1;
        read_status(1'b1, 1, "R10 set with bit3");
        cmd1(1'b0, 8'h04); exp_wel = 1'b0;
        read_status(1'b0, 1, "R5 clear");

        // status write gated by enable
        sel(1'b0); xfer(1'b0, 8'h01, rx); xfer(1'b0, 8'h0C, rx); desel();
        read_status(1'b0, 1, "R7 status write without enable");
        cmd1(1'b0, 8'h06);
        sel(1'b1); xfer(1'b1, 8'h09, rx); xfer(1'b1, 8'h0C, rx); desel();
        exp_bp = 2'b11; exp_wel = 1'b0;
        read_status(1'b0, 1, "R7 R10 status write with enable");
        cmd1(1'b0, 8'h06);
        sel(1'b0); xfer(1'b0, 8'h01, rx); xfer(1'b0, 8'h00, rx); desel();
        exp_bp = 2'b00; exp_wel = 1'b0;
        read_status(1'b1, 1, "R7 status cleared");

        // array write without enable
        w0 = n_wr;
        do_write(1'b0, 9'h010, 5, 1'b0);
        check(n_wr == w0, "R4 write without enable", n_wr - w0, 0);
        do_read(1'b0, 9'h010, 5, 1'b1);

        // page wrap and commit, top page, 20 bytes from 0x1F8
        cmd1(1'b0, 8'h06); exp_wel = 1'b1;
        w0 = n_wr;
        do_write(1'b0, 9'h1F8, 20, 1'b1);
        check(n_wr - w0 == 16, "R4 commit count", n_wr - w0, 16);
        read_status(1'b0, 1, "R4 enable cleared after commit");
        do_read(1'b1, 9'h1F0, 18, 1'b1);     // crosses 0x1FF -> 0x000 (R3)

        // address bit 8 taken from opcode bit 3
        do_read(1'b0, 9'h0F4, 3, 1'b1);
        do_read(1'b0, 9'h1F4, 3, 1'b1);

        // unknown opcodes
        foreach (rx[i]) ;
        for (int t = 0; t < 3; t++) begin
            logic [7:0] bad;
            bad = (t == 0) ? 8'hFF : (t == 1) ? 8'h07 : 8'h86;
            s0 = n_strobe; o0 = n_oe;
            sel(t[0]);
            xfer(t[0], bad, rx);
            xfer(t[0], 8'h06, rx);
            xfer(t[0], 8'h05, rx);
            xfer(t[0], 8'h03, rx);
            desel();
            check(n_strobe == s0, "R8 no strobe after bad opcode", n_strobe - s0, 0);
            check(n_oe == o0, "R8 output off after bad opcode", n_oe - o0, 0);
        end
        read_status(1'b0, 1, "R8 status untouched");

        // random mix
        for (int it = 0; it < 36; it++) begin
            bit m3;
            logic [8:0] a;
            m3 = 1'($urandom);
            a  = 9'($urandom);
            if ((($urandom) % 3) == 0) begin
                cmd1(m3, 8'h06); exp_wel = 1'b1;
                do_write(m3, a, 1 + int'($urandom % 20), 1'b1);
                do_read(~m3, {a[8:4], 4'h0}, 16, 1'b1);
            end else begin
                do_read(m3, a, 1 + int'($urandom % 6), 1'b1);
            end
        end

        check(n_hiz_bad == 0, "R9 output off while deselected", n_hiz_bad, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule